// File: doc/BRIEF.md
# Asynchronous Byte-Wide Memory Read Sequencer

This block sits on the host side of a slow, asynchronous, byte-wide read-only memory and turns single-cycle read requests into correctly timed pin activity. A request carries a 19-bit address and is taken on a synchronous valid/ready handshake. The block then drives the address, pulls chip enable low and, after a set lag, pulls output enable low. It samples the 8-bit data once every access-time budget has elapsed. It returns that byte with a one-cycle response strobe and then keeps the bus closed for the output float time.

The clock period and the memory's timing figures (address access, chip-enable access, output-enable access and output float, all in nanoseconds) are parameters. They are converted to whole clock cycles at elaboration, always rounding up, with at least one cycle for each. Output enable is not asserted together with chip enable. It is held back by the largest safe lag, which is the longer of the two access times minus the output-enable access time, rounded down. This keeps the window in which the memory drives the bus as short as possible without lengthening the read. Chip enable stays low across chained reads and returns high only when no request is waiting at the moment the float time runs out. The memory then drops to its low-power standby.

With the default parameters (4 ns clock, 120/120/50/45 ns), the counts are as follows. Output enable falls 17 cycles after acceptance. Data is sampled 30 cycles after acceptance. The next request can be accepted 12 cycles after output enable rises.

Top module: `amem_rd_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, mem_ce_n and mem_oe_n are 1, req_ready is 1 and rsp_valid is 0, whatever req_valid does.
- R2: A request is taken at a rising clock edge where req_valid and req_ready are both 1. From that edge on, mem_addr shows the request address and mem_ce_n is 0.
- R3: mem_oe_n falls LAG clock edges after the accepting edge. LAG is the larger of the address and chip-enable access times, minus the output-enable access time, divided by the clock period and rounded down, with a minimum of 1.
- R4: At the edge SAMP cycles after acceptance, the value on mem_data_i is captured. rsp_valid is then 1 for exactly one cycle with that byte on rsp_data. SAMP is the largest of ceil(address access), ceil(chip-enable access) and LAG + ceil(output-enable access), all measured in cycles.
- R5: mem_oe_n rises at the same edge that captures the data. mem_addr and mem_ce_n are still unchanged at that edge, so the memory's zero hold time is respected.
- R6: After mem_oe_n rises, req_ready stays 0 for DF-1 cycles and becomes 1 in the following cycle. DF is ceil(output float time / clock period), with a minimum of 1. As a result, a new access begins no sooner than DF cycles after output enable rises.
- R7: If a request is accepted in the cycle that ends the float time, mem_ce_n stays 0 without a break and the new address appears at once.
- R8: If no request is accepted in the cycle that ends the float time, mem_ce_n goes to 1 at the next edge. It stays 1 until a request is accepted.
- R9: While a read is in progress, req_ready is 0 and req_valid has no effect on mem_addr, mem_ce_n, mem_oe_n or the sequence timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 19 | Byte address of the request |
| req_ready | output | 1 | Controller can take a request this cycle |
| rsp_valid | output | 1 | One-cycle strobe marking rsp_data |
| rsp_data | output | 8 | Byte read from the memory |
| mem_addr | output | 19 | Address pins of the memory |
| mem_ce_n | output | 1 | Chip enable to the memory, active low |
| mem_oe_n | output | 1 | Output enable to the memory, active low |
| mem_data_i | input | 8 | Data pins of the memory |

## Verification
The hardest case to reach is the single cycle that ends the float time. In that cycle, whether a request is waiting decides between keeping chip enable low and releasing it. To reach it, the stimulus holds req_valid high with a new address every cycle, so every read is chained straight into that cycle, and separately idles until exactly one cycle after it before sending a request. The bench memory model returns inverted data unless every access time is met to the exact cycle, so a sample taken one cycle early is caught as a data error.

// File: rtl/amem_rd_pkg.sv
`timescale 1ns/1ps
package amem_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ENABLE = 2'd2,
    ST_FLOAT  = 2'd3
  } rd_state_e;

  // nanoseconds to cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  // largest safe lag from chip enable to output enable, rounded down, at least one
  function automatic int unsigned oe_lag_cyc(input int unsigned acc_ns, input int unsigned ce_ns,
                                             input int unsigned oe_ns, input int unsigned per);
    int unsigned lng;
    int unsigned c;
    lng = (acc_ns > ce_ns) ? acc_ns : ce_ns;
    c = (lng > oe_ns) ? (lng - oe_ns) / per : 0;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/amem_rd_delay.sv
`timescale 1ns/1ps
module amem_rd_delay #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_en = load || !done;
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/amem_rd_seq.sv
`timescale 1ns/1ps
module amem_rd_seq
  import amem_rd_pkg::*;
#(
  parameter int unsigned LAG_C  = 17,
  parameter int unsigned SAMP_C = 30,
  parameter int unsigned DF_C   = 12,
  parameter int unsigned CNT_W  = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  output logic      req_ready,
  output logic      accept,
  output logic      capture,
  output rd_state_e state_nx
);

  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(LAG_C - 1);
  localparam logic [CNT_W-1:0] LD_ENABLE = CNT_W'(SAMP_C - LAG_C - 1);
  localparam logic [CNT_W-1:0] LD_FLOAT  = CNT_W'(DF_C - 1);

  rd_state_e        state_q;
  rd_state_e        state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             done;

  amem_rd_delay #(.CNT_W(CNT_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    accept    = 1'b0;
    capture   = 1'b0;
    req_ready = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          accept   = 1'b1;
          state_d  = ST_SETUP;
          load     = 1'b1;
          load_val = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (done) begin
          state_d  = ST_ENABLE;
          load     = 1'b1;
          load_val = LD_ENABLE;
        end
      end
      ST_ENABLE: begin
        if (done) begin
          capture  = 1'b1;
          state_d  = ST_FLOAT;
          load     = 1'b1;
          load_val = LD_FLOAT;
        end
      end
      ST_FLOAT: begin
        if (done) begin
          req_ready = 1'b1;
          if (req_valid) begin
            accept   = 1'b1;
            state_d  = ST_SETUP;
            load     = 1'b1;
            load_val = LD_SETUP;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_nx = state_d;

endmodule

// File: rtl/amem_rd_pins.sv
`timescale 1ns/1ps
module amem_rd_pins
  import amem_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  rd_state_e         state_nx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [ADDR_W-1:0] addr_q;
  logic              ce_n_q;
  logic              oe_n_q;
  logic              rsp_v_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      rsp_v_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
      end
      ce_n_q  <= (state_nx == ST_IDLE);
      oe_n_q  <= (state_nx != ST_ENABLE);
      rsp_v_q <= capture;
      if (capture) begin
        data_q <= mem_data_i;
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_oe_n  = oe_n_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/amem_rd_ctrl.sv
`timescale 1ns/1ps
module amem_rd_ctrl
  import amem_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 4,
  parameter int unsigned T_ACC_NS   = 120,
  parameter int unsigned T_CE_NS    = 120,
  parameter int unsigned T_OE_NS    = 50,
  parameter int unsigned T_FLOAT_NS = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_data_i
);

  localparam int unsigned ACC_C  = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int unsigned CE_C   = ns_to_cyc(T_CE_NS, CLK_NS);
  localparam int unsigned OE_C   = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int unsigned DF_C   = ns_to_cyc(T_FLOAT_NS, CLK_NS);
  localparam int unsigned LAG_C  = oe_lag_cyc(T_ACC_NS, T_CE_NS, T_OE_NS, CLK_NS);
  localparam int unsigned SAMP_C = max3(ACC_C, CE_C, LAG_C + OE_C);
  localparam int unsigned CNT_W  = $clog2(max3(SAMP_C, DF_C, 2) + 1);

  logic      accept;
  logic      capture;
  rd_state_e state_nx;

  amem_rd_seq #(
    .LAG_C  (LAG_C),
    .SAMP_C (SAMP_C),
    .DF_C   (DF_C),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .state_nx  (state_nx)
  );

  amem_rd_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .state_nx   (state_nx),
    .req_addr   (req_addr),
    .mem_data_i (mem_data_i),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

endmodule

// File: rtl/amem_rd_ctrl_chk.sv
`timescale 1ns/1ps
module amem_rd_ctrl_chk
  import amem_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned CLK_NS     = 4,
  parameter int unsigned T_FLOAT_NS = 45
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n
);

  localparam int unsigned DF_C = ns_to_cyc(T_FLOAT_NS, CLK_NS);

  // cycles that output enable has been high, saturating at DF_C
  int unsigned since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_oe <= DF_C;
    end else if (!mem_oe_n) begin
      since_oe <= 0;
    end else if (since_oe < DF_C) begin
      since_oe <= since_oe + 1;
    end
  end

  p_ce_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_ce_n);

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_oe_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

  p_rsp_at_oe_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(mem_oe_n));

  p_float_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !mem_ce_n) |-> (since_oe + 1 >= DF_C));

  p_release_after_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> ($past(req_ready) && !$past(req_valid)));

  p_addr_moves_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(req_valid && req_ready));

  p_no_take_while_driving_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> mem_oe_n);

endmodule

bind amem_rd_ctrl amem_rd_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .CLK_NS     (CLK_NS),
  .T_FLOAT_NS (T_FLOAT_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/amem_rd_ctrl_test.sv
`timescale 1ns/1ps
module amem_rd_ctrl_test;

  localparam int PER   = 4;
  localparam int TACC  = 120;
  localparam int TCE   = 120;
  localparam int TOE   = 50;
  localparam int TDF   = 45;
  // expected cycle counts from the requirements
  localparam int E_LAG  = (TACC - TOE) / PER;
  localparam int E_SAMP = ((TACC + PER - 1) / PER > E_LAG + (TOE + PER - 1) / PER) ?
                          (TACC + PER - 1) / PER : E_LAG + (TOE + PER - 1) / PER;
  localparam int E_DF   = (TDF + PER - 1) / PER;
  // memory model delays in cycles
  localparam int M_ACC = 30;
  localparam int M_CE  = 30;
  localparam int M_OE  = 13;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [18:0] req_addr;
  logic        req_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [18:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic [7:0]  mem_data_i;

  int n_chk;
  int n_fail;

  // reference state
  bit          busy;
  int          k;
  logic [18:0] m_addr;
  bit          chained;
  bit          ignored;
  // memory model state
  logic [18:0] p_addr;
  logic        p_ce;
  logic        p_oe;
  int          c_addr;
  int          c_ce;
  int          c_oe;

  amem_rd_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_data_i (mem_data_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] rom(input logic [18:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ {a[18:16], 5'b10101};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic mem_model();
    bit ok;
    c_addr = (mem_addr != p_addr) ? 0 : c_addr + 1;
    c_ce   = (!mem_ce_n && p_ce) ? 0 : c_ce + 1;
    c_oe   = (!mem_oe_n && p_oe) ? 0 : c_oe + 1;
    p_addr = mem_addr;
    p_ce   = mem_ce_n;
    p_oe   = mem_oe_n;
    ok = !mem_ce_n && !mem_oe_n && (c_addr + 1 >= M_ACC) && (c_ce + 1 >= M_CE) && (c_oe + 1 >= M_OE);
    if (ok)            mem_data_i = rom(mem_addr);
    else if (!mem_oe_n) mem_data_i = ~rom(mem_addr);
    else               mem_data_i = 8'h00;
  endtask

  // one cycle: model memory, compare, then drive the next request
  task automatic step(input logic v, input logic [18:0] a);
    bit exp_ready;
    bit acc;
    @(negedge clk);
    mem_model();
    exp_ready = !busy || (k == E_SAMP + E_DF - 1);
    chk(chained && busy && k == 0 ? "R7" : "R8", "mem_ce_n", mem_ce_n, !busy);
    chk("R3", "mem_oe_n", mem_oe_n, !(busy && k >= E_LAG && k < E_SAMP));
    chk("R6", "req_ready", req_ready, exp_ready);
    chk("R4", "rsp_valid", rsp_valid, busy && k == E_SAMP);
    if (busy && k == E_SAMP) chk("R4", "rsp_data", rsp_data, rom(m_addr));
    if (busy) chk(k == E_SAMP ? "R5" : (ignored ? "R9" : "R2"), "mem_addr", mem_addr, m_addr);
    acc     = v && exp_ready;
    ignored = v && !exp_ready;
    if (acc) begin
      chained = busy;
      busy    = 1;
      k       = 0;
      m_addr  = a;
    end else if (busy) begin
      k++;
      if (k == E_SAMP + E_DF) busy = 0;
    end
    req_valid = v;
    req_addr  = a;
  endtask

  task automatic idle_until_free();
    while (busy) step(1'b0, 19'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    busy = 0; k = 0; m_addr = '0; chained = 0; ignored = 0;
    p_addr = '0; p_ce = 1; p_oe = 1; c_addr = 1000; c_ce = 1000; c_oe = 1000;
    mem_data_i = 8'h00;
    rst_n = 1'b0;
    req_valid = 1'b1;          // request held during reset must be ignored
    req_addr = 19'h12345;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "mem_ce_n", mem_ce_n, 1);
      chk("R1", "mem_oe_n", mem_oe_n, 1);
      chk("R1", "req_ready", req_ready, 1);
      chk("R1", "rsp_valid", rsp_valid, 0);
    end
    req_valid = 1'b0;
    rst_n = 1'b1;
    step(1'b0, 19'h0);

    // single read at the lowest address, then at the highest
    step(1'b1, 19'h00000);
    idle_until_free();
    repeat (3) step(1'b0, 19'h0);
    step(1'b1, 19'h7FFFF);
    idle_until_free();
    repeat (3) step(1'b0, 19'h0);

    // requests every cycle with changing address: busy-time requests ignored, chained reads
    for (int i = 0; i < 200; i++) step(1'b1, 19'(i * 37 + 5));
    idle_until_free();

    // request arrives one cycle after the float time ends: chip enable released first
    step(1'b1, 19'h2A5C3);
    while (!(busy && k == E_SAMP + E_DF - 1)) step(1'b0, 19'h0);
    step(1'b0, 19'h0);
    step(1'b1, 19'h5A5A5);
    idle_until_free();

    // single-cycle requests that land while busy
    step(1'b1, 19'h01234);
    for (int i = 0; i < 50; i++) step(i % 3 == 0, 19'(i * 1111));
    idle_until_free();
    repeat (4) step(1'b0, 19'h0);

    summary();
    $finish;
  end

endmodule